// File: doc/BRIEF.md
# Phased Four-Port Thread Register File

This block holds the register banks of a four-thread processing element. All of them sit in one synchronous dual-port RAM. Two clocks make one micro cycle, and on each of them both RAM ports are used.

On the first clock (phase 0) the two RAM ports read the two source operands. On the second clock (phase 1) one port writes the result and the other reads an instruction word.

Each thread owns a bank of 64 registers. The bank is selected by the thread number, and the register number picks the word inside it. Register 0 is a one-shot temporary. It reads as zero unless a value has been written to it since the last read. That value is returned exactly once, and the pending state is kept separately for every thread.

Register numbers of 64 or more are not held in the RAM. An access to such a number raises an overflow flag and does not touch the RAM.

Top module: `mt_regfile`

## Requirements
- R1: After reset `phase` is 0, and it inverts on every clock. A rising edge taken with `phase`=0 is a phase-0 edge, which samples `tid`, `rs_a` and `rs_b`. A rising edge taken with `phase`=1 is a phase-1 edge, which samples `tid`, `wr_en`, `wr_reg`, `wr_data` and `fetch_addr`. The caller holds all inputs for the whole micro cycle.
- R2: Operand results and the overflow flag sampled at a phase-0 edge appear after the following phase-1 edge. They stay unchanged until the next phase-1 edge.
- R3: A write with `wr_en`=1 stores `wr_data` into register `wr_reg` of thread `tid` at the phase-1 edge. A read in a later micro cycle returns the stored value. A read in the same micro cycle returns the earlier value.
- R4: Banks are private. Register n of one thread is independent of register n of any other thread.
- R5: `fetch_addr` is the RAM word index `tid*64 + register`. It is sampled at a phase-1 edge, and that word appears on `fetch_word` after the next phase-0 edge. It is held for one micro cycle.
- R6: Reading register 0 returns zero when no write to it is pending for that thread.
- R7: After register 0 of a thread is written, the next micro cycle that reads it returns the written value. This holds on either operand, and on both operands if both name register 0. Every later read returns zero until the next write. The pending state is kept per thread.
- R8: A write to register 0 in a micro cycle that also consumes it does two things. The read gets the earlier value, and the new value becomes pending.
- R9: A register number of 64 or more (bit 6 set) on either read or on an enabled write sets `ovf` for that micro cycle. Such a read returns zero and does not consume register 0. Such a write changes no register and sets no pending state.
- R10: Reset clears `opnd_a`, `opnd_b`, `fetch_word` and `ovf` to zero and drops every pending register-0 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | output | 1 | Current micro-cycle phase (0 = next edge reads operands) |
| tid | input | 2 | Thread number |
| rs_a | input | 7 | First source register number |
| rs_b | input | 7 | Second source register number |
| wr_en | input | 1 | Result write enable |
| wr_reg | input | 7 | Destination register number |
| wr_data | input | 32 | Result value |
| fetch_addr | input | 8 | Instruction word index into the RAM |
| opnd_a | output | 32 | First operand value |
| opnd_b | output | 32 | Second operand value |
| fetch_word | output | 32 | Fetched instruction word |
| ovf | output | 1 | Register number beyond the bank in this micro cycle |

## Verification
The operand path is tried with several patterns, and each one tells a different fault apart:
- A plain write followed by a read shows that data reaches the right word.
- A read and a write to the same register in one micro cycle shows that the write is ordered after the read.
- The same register number under two threads exposes a bank-select fault.
- A fetch of a word written earlier shows that the fetch port reads the same storage.

Register 0 gets its own sequences:
- a read with nothing pending;
- one write followed by two reads;
- both operands naming register 0 at once;
- a write in the consuming micro cycle;
- a pending value in one thread while another thread reads.

Each of these separates a correct one-shot from a plain zero register, from an ordinary register, and from a flag that is shared between threads. Overflowing numbers 64 and 65 are written over live registers 0 and 1. This exposes address aliasing that a missing suppression would cause.

// File: rtl/mt_regfile.sv
module mt_regfile #(
  parameter int THREADS = 4,
  parameter int REGS    = 64,
  parameter int DATA_W  = 32,
  localparam int TID_W  = $clog2(THREADS),
  localparam int IDX_W  = $clog2(REGS),
  localparam int RN_W   = IDX_W + 1,
  localparam int AW     = TID_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              phase,
  input  logic [TID_W-1:0]  tid,
  input  logic [RN_W-1:0]   rs_a,
  input  logic [RN_W-1:0]   rs_b,
  input  logic              wr_en,
  input  logic [RN_W-1:0]   wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     fetch_addr,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] fetch_word,
  output logic              ovf
);
  localparam int DEPTH = THREADS * REGS;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] qa, qb;
  logic [TID_W-1:0]  c_tid;
  logic [RN_W-1:0]   c_ra, c_rb;
  logic [THREADS-1:0] r0v;

  wire ra_big  = c_ra[IDX_W];
  wire rb_big  = c_rb[IDX_W];
  wire wr_big  = wr_reg[IDX_W];
  wire w_hit   = wr_en && !wr_big;
  wire w_r0    = w_hit && (wr_reg[IDX_W-1:0] == '0);
  wire a_r0    = !ra_big && (c_ra[IDX_W-1:0] == '0);
  wire b_r0    = !rb_big && (c_rb[IDX_W-1:0] == '0);
  wire r0_live = r0v[c_tid];

  wire [DATA_W-1:0] val_a = ra_big ? '0 : (a_r0 && !r0_live) ? '0 : qa;
  wire [DATA_W-1:0] val_b = rb_big ? '0 : (b_r0 && !r0_live) ? '0 : qb;

  always_ff @(posedge clk)
    if (phase && w_hit)
      mem[{tid, wr_reg[IDX_W-1:0]}] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= 1'b0;
      qa         <= '0;
      qb         <= '0;
      c_tid      <= '0;
      c_ra       <= '0;
      c_rb       <= '0;
      r0v        <= '0;
      opnd_a     <= '0;
      opnd_b     <= '0;
      fetch_word <= '0;
      ovf        <= 1'b0;
    end else begin
      phase <= ~phase;
      if (!phase) begin
        c_tid      <= tid;
        c_ra       <= rs_a;
        c_rb       <= rs_b;
        fetch_word <= qb;
        if (!rs_a[IDX_W]) qa <= mem[{tid, rs_a[IDX_W-1:0]}];
        if (!rs_b[IDX_W]) qb <= mem[{tid, rs_b[IDX_W-1:0]}];
      end else begin
        qb     <= mem[fetch_addr];
        opnd_a <= val_a;
        opnd_b <= val_b;
        ovf    <= ra_big || rb_big || (wr_en && wr_big);
        for (int t = 0; t < THREADS; t++) begin
          if (w_r0 && tid == TID_W'(t))
            r0v[t] <= 1'b1;
          else if (c_tid == TID_W'(t) && (a_r0 || b_r0))
            r0v[t] <= 1'b0;
        end
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |=> $stable(opnd_a) && $stable(opnd_b) && $stable(ovf)); // R2

  AST_R0_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    phase && (a_r0 || b_r0) && !(w_r0 && tid == c_tid) |=> !r0v[c_tid]); // R7

  AST_R0_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    phase && w_r0 |=> r0v[$past(tid)]); // R8

  AST_R0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    phase && a_r0 && !r0_live |=> opnd_a == '0); // R6

  AST_BIG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    phase && ra_big |=> ovf && opnd_a == '0); // R9

  AST_BIG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    phase && wr_en && wr_big && !(a_r0 || b_r0) |=> $stable(r0v)); // R9
endmodule

// File: tb/mt_regfile_test.sv
`timescale 1ns/1ps
module mt_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase;
  logic [1:0]  tid = '0;
  logic [6:0]  rs_a = 7'd1, rs_b = 7'd1, wr_reg = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  fetch_addr = '0;
  logic [31:0] opnd_a, opnd_b, fetch_word;
  logic        ovf;

  int errors = 0, checks = 0;
  logic [31:0] got_a, got_b, mid_a, got_f;
  logic        got_o;

  always #4 clk = ~clk;

  mt_regfile uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic uc(input logic [1:0] t, input logic [6:0] a, input logic [6:0] b,
                    input logic w, input logic [6:0] wa, input logic [31:0] d,
                    input logic [7:0] f);
    while (phase) @(negedge clk);
    tid = t; rs_a = a; rs_b = b; wr_en = w; wr_reg = wa; wr_data = d; fetch_addr = f;
    @(posedge clk); @(negedge clk);
    mid_a = opnd_a; got_f = fetch_word;
    @(posedge clk); @(negedge clk);
    got_a = opnd_a; got_b = opnd_b; got_o = ovf;
  endtask

  task automatic t_reset;
    chk("R10 opnd_a", opnd_a, 0);
    chk("R10 opnd_b", opnd_b, 0);
    chk("R10 fetch", fetch_word, 0);
    chk("R10 ovf", {31'd0, ovf}, 0);
    chk("R1 phase after reset", {31'd0, phase}, 0);
    @(negedge clk);
    chk("R1 phase toggles", {31'd0, phase}, 1);
    @(negedge clk);
  endtask

  task automatic t_write_read;
    uc(0, 1, 1, 1, 5, 32'hA0A0_0005, 0);
    uc(0, 5, 1, 1, 5, 32'hB0B0_0005, 0);
    chk("R3 write then read", got_a, 32'hA0A0_0005);
    uc(0, 5, 5, 0, 0, 0, 0);
    chk("R2 hold until phase-1 edge", mid_a, 32'hA0A0_0005);
    chk("R3 same-cycle write ordered after read", got_a, 32'hB0B0_0005);
    chk("R3 second port", got_b, 32'hB0B0_0005);
  endtask

  task automatic t_banks;
    uc(1, 1, 1, 1, 5, 32'hC1C1_0005, 0);
    uc(0, 5, 1, 0, 0, 0, 0);
    chk("R4 thread 0 unchanged", got_a, 32'hB0B0_0005);
    uc(1, 1, 5, 0, 0, 0, 0);
    chk("R4 thread 1 own value", got_b, 32'hC1C1_0005);
  endtask

  task automatic t_fetch;
    uc(2, 1, 1, 1, 9, 32'hF00D_0209, 0);
    uc(2, 1, 1, 0, 0, 0, 8'd137);
    uc(0, 1, 1, 0, 0, 0, 0);
    chk("R5 fetch word", got_f, 32'hF00D_0209);
  endtask

  task automatic t_r0;
    uc(3, 0, 1, 0, 0, 0, 0);
    chk("R6 r0 idle zero", got_a, 0);
    uc(0, 1, 1, 1, 0, 32'h1111_0000, 0);
    uc(0, 1, 0, 0, 0, 0, 0);
    chk("R7 r0 first read", got_b, 32'h1111_0000);
    uc(0, 0, 1, 0, 0, 0, 0);
    chk("R7 r0 second read zero", got_a, 0);
    uc(0, 1, 1, 1, 0, 32'h2222_0000, 0);
    uc(0, 0, 0, 0, 0, 0, 0);
    chk("R7 both operands a", got_a, 32'h2222_0000);
    chk("R7 both operands b", got_b, 32'h2222_0000);
    uc(0, 0, 0, 0, 0, 0, 0);
    chk("R7 both consumed", got_a, 0);
    uc(1, 1, 1, 1, 0, 32'h3333_0001, 0);
    uc(0, 0, 1, 0, 0, 0, 0);
    chk("R7 other thread not pending", got_a, 0);
    uc(1, 0, 1, 0, 0, 0, 0);
    chk("R7 per-thread value", got_a, 32'h3333_0001);
  endtask

  task automatic t_r0_rewrite;
    uc(2, 1, 1, 1, 0, 32'h4444_0002, 0);
    uc(2, 0, 1, 1, 0, 32'h5555_0002, 0);
    chk("R8 read gets earlier", got_a, 32'h4444_0002);
    uc(2, 0, 1, 0, 0, 0, 0);
    chk("R8 new value pending", got_a, 32'h5555_0002);
    uc(2, 0, 1, 0, 0, 0, 0);
    chk("R8 then zero", got_a, 0);
  endtask

  task automatic t_ovf;
    uc(3, 1, 1, 1, 1, 32'h6666_0301, 0);
    uc(3, 7'd67, 1, 0, 0, 0, 0);
    chk("R9 big read zero", got_a, 0);
    chk("R9 ovf on read", {31'd0, got_o}, 1);
    chk("R9 other port normal", got_b, 32'h6666_0301);
    uc(3, 1, 1, 1, 7'd64, 32'hDEAD_0040, 0);
    chk("R9 ovf on write", {31'd0, got_o}, 1);
    uc(3, 1, 1, 1, 7'd65, 32'hDEAD_0041, 0);
    uc(3, 0, 1, 0, 0, 0, 0);
    chk("R9 write 64 sets no r0", got_a, 0);
    chk("R9 write 65 keeps reg 1", got_b, 32'h6666_0301);
    chk("R9 ovf clears", {31'd0, got_o}, 0);
    uc(3, 1, 1, 1, 0, 32'h7777_0300, 0);
    uc(3, 7'd64, 1, 0, 0, 0, 0);
    uc(3, 0, 1, 0, 0, 0, 0);
    chk("R9 big read does not consume r0", got_a, 32'h7777_0300);
  endtask

  initial begin
    #100000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre();
  end

  task automatic t_reset_pre;
    chk("R10 held in reset phase", {31'd0, phase}, 0);
    rst_n = 1'b1;
    t_reset;
    t_write_read;
    t_banks;
    t_fetch;
    t_r0;
    t_r0_rewrite;
    t_ovf;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask
endmodule